// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that works through a list of up to 16 transfers held in an internal entry memory, with no host action between transfers. Each entry holds a transmit word, a length code and a 4-bit peripheral-select code. The host loads entries through a write port, sets a first and a last entry index, and pulses `start`. The controller then fetches each entry in turn. It drives the select code, shifts the word out on `mosi` while it clocks `sck`, and collects the bits on `miso` at the same time. It stores each received word in a receive slot of the same index, which the host can read back at any time.

The bus runs in SPI mode 0. Each word goes out most significant bit first, and its length can be 8 to 16 bits, set per entry. The serial clock is the system clock divided by a programmable even divisor. With wrap mode off, the controller stops after the last entry and raises `done`. With wrap mode on, it goes back to the first entry and keeps going, so the receive slots always hold fresh samples from a peripheral that is read over and over.

Top module: `qspi_master`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sck` is 0, `psel` is 4'b1111, and `busy` and `done` are 0. A reset in the middle of a transfer abandons that transfer.
- R2: A `start` pulse seen while idle sets `busy` to 1 and `done` to 0 on the next clock edge. A `start` seen while busy has no effect on the running sequence.
- R3: Entries run in ascending index order from `start_ptr` to `end_ptr`, and the index wraps from 15 to 0.
- R4: An entry with length code L sends L+1 bits for L from 7 to 15. A code below 7 sends 8 bits. The bits sent are the low bits of the transmit word, most significant first.
- R5: `sck` rests low. `mosi` changes only while `sck` is low, so it is stable at each rising edge. `miso` is sampled on the rising edge.
- R6: The word received for an entry is written to that entry's receive slot, right-aligned with the upper bits zero. `rd_data` shows the slot addressed by `rd_addr` one clock later.
- R7: Each half period of `sck` lasts floor(`clk_div`/2) system clocks, with a minimum of 2. A divisor of 3 therefore gives a period of 4, and a divisor of 9 gives a period of 8.
- R8: The entry's select code is on `psel` before the first rising edge of `sck` and stays there past the last falling edge. Between entries and while idle, `psel` is 4'b1111.
- R9: With wrap mode off, after the entry at `end_ptr` completes, `busy` falls and `done` rises together.
- R10: With wrap mode on, after the entry at `end_ptr` the controller continues from `start_ptr` and overwrites the receive slots. If `wrap_en` is cleared, the controller stops at the next completion of the `end_ptr` entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ent_we | input | 1 | Write enable for one queue entry |
| ent_addr | input | 4 | Index of the entry to write |
| ent_tx | input | 16 | Transmit word of the entry |
| ent_len | input | 4 | Length code of the entry (bits = code+1, at least 8) |
| ent_sel | input | 4 | Peripheral-select code of the entry |
| rd_addr | input | 4 | Receive slot to read |
| rd_data | output | 16 | Receive slot contents, one cycle after `rd_addr` |
| start | input | 1 | Starts a run when idle |
| wrap_en | input | 1 | Loops back to `start_ptr` after `end_ptr` |
| start_ptr | input | 4 | First entry index |
| end_ptr | input | 4 | Last entry index |
| clk_div | input | 8 | System clocks per `sck` period (even, minimum 4) |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| psel | output | 4 | Encoded peripheral select, all ones when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run finished without wrapping |

## Verification
A wrong internal state shows up at the ports within one entry. A bad entry pointer puts the wrong select code on `psel` at the start of the next entry. A bad bit counter sends a word that is too short or too long, so the count of `sck` rising edges under one select code is wrong. A bad receive shift shows up when the host reads back that slot after the run. The bench models a slave that records every `mosi` word and select code in the order it sees them and sends a known word for each transfer. This exposes pointer-order faults (including the wrap from 15 to 0) as soon as the first wrong entry is selected. Divider faults are caught by timing the gap between `sck` rising edges.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_XFER,
    ST_WRITE
  } qstate_t;

endpackage

// File: rtl/qspi_dpram.sv
module qspi_dpram #(
  parameter int W = 16,
  parameter int D = 16,
  localparam int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);

  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end

endmodule

// File: rtl/qspi_halftick.sv
module qspi_halftick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt;

  // half period: floor(div/2), never below 2
  always_comb begin
    half = {1'b0, div[DIV_W-1:1]};
    if (half < DIV_W'(2)) half = DIV_W'(2);
  end

  assign tick = run && (cnt == half - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end

endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  tx_word,
  input  logic [CW-1:0] nbits,
  input  logic          rise,
  input  logic          fall,
  input  logic          miso,
  output logic          mosi,
  output logic [W-1:0]  rx_word,
  output logic          last
);

  logic [W-1:0]  txs;
  logic [W-1:0]  aligned;
  logic [CW-1:0] bcnt;

  // move the word's top bit to the register MSB
  assign aligned = tx_word << (CW'(W) - nbits);
  assign last    = (bcnt == nbits - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      txs     <= '0;
      mosi    <= 1'b0;
      rx_word <= '0;
      bcnt    <= '0;
    end else if (load) begin
      txs     <= aligned;
      mosi    <= aligned[W-1];
      rx_word <= '0;
      bcnt    <= '0;
    end else begin
      if (rise) rx_word <= {rx_word[W-2:0], miso};
      if (fall) begin
        txs  <= txs << 1;
        mosi <= txs[W-2];
        bcnt <= bcnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int WMAX     = 16,
  parameter int SEL_W    = 4,
  parameter int DIV_W    = 8,
  parameter int MIN_BITS = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(WMAX),
  localparam int CW    = $clog2(WMAX + 1),
  localparam int EW    = WMAX + LEN_W + SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ent_we,
  input  logic [AW-1:0]    ent_addr,
  input  logic [WMAX-1:0]  ent_tx,
  input  logic [LEN_W-1:0] ent_len,
  input  logic [SEL_W-1:0] ent_sel,
  input  logic [AW-1:0]    rd_addr,
  output logic [WMAX-1:0]  rd_data,
  input  logic             start,
  input  logic             wrap_en,
  input  logic [AW-1:0]    start_ptr,
  input  logic [AW-1:0]    end_ptr,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic [SEL_W-1:0] psel,
  output logic             busy,
  output logic             done
);

  qstate_t          st;
  logic [AW-1:0]    ptr;
  logic [AW-1:0]    ptr_next;
  logic             sck_q;
  logic [SEL_W-1:0] psel_q;
  logic             busy_q;
  logic             done_q;
  logic [CW-1:0]    nbits_q;
  logic [CW-1:0]    nb_dec;
  logic [CW-1:0]    nb_use;

  logic [EW-1:0]    ent_rd;
  logic [WMAX-1:0]  e_tx;
  logic [LEN_W-1:0] e_len;
  logic [SEL_W-1:0] e_sel;

  logic             tick;
  logic             rise;
  logic             fall;
  logic             last;
  logic [WMAX-1:0]  rx_word;

  // entry store: host writes, sequencer reads at ptr
  qspi_dpram #(.W(EW), .D(DEPTH)) u_entries (
    .clk (clk),
    .we  (ent_we),
    .wa  (ent_addr),
    .wd  ({ent_tx, ent_len, ent_sel}),
    .ra  (ptr),
    .rd  (ent_rd)
  );

  // receive slots: sequencer writes, host reads
  qspi_dpram #(.W(WMAX), .D(DEPTH)) u_rxslots (
    .clk (clk),
    .we  (st == ST_WRITE),
    .wa  (ptr),
    .wd  (rx_word),
    .ra  (rd_addr),
    .rd  (rd_data)
  );

  assign e_tx  = ent_rd[EW-1 -: WMAX];
  assign e_len = ent_rd[SEL_W +: LEN_W];
  assign e_sel = ent_rd[SEL_W-1:0];

  always_comb begin
    nb_dec = CW'(e_len) + CW'(1);
    if (nb_dec < CW'(MIN_BITS)) nb_dec = CW'(MIN_BITS);
  end

  assign nb_use   = (st == ST_LOAD) ? nb_dec : nbits_q;
  assign ptr_next = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);

  qspi_halftick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (st == ST_XFER),
    .div  (clk_div),
    .tick (tick)
  );

  assign rise = tick && !sck_q;
  assign fall = tick &&  sck_q;

  qspi_shift #(.W(WMAX), .CW(CW)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (st == ST_LOAD),
    .tx_word (e_tx),
    .nbits   (nb_use),
    .rise    (rise),
    .fall    (fall),
    .miso    (miso),
    .mosi    (mosi),
    .rx_word (rx_word),
    .last    (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ptr     <= '0;
      sck_q   <= 1'b0;
      psel_q  <= '1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      nbits_q <= CW'(MIN_BITS);
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            ptr    <= start_ptr;
            busy_q <= 1'b1;
            done_q <= 1'b0;
            st     <= ST_FETCH;
          end
        end
        ST_FETCH: st <= ST_LOAD;
        ST_LOAD: begin
          psel_q  <= e_sel;
          nbits_q <= nb_dec;
          st      <= ST_XFER;
        end
        ST_XFER: begin
          if (tick) begin
            if (!sck_q) begin
              sck_q <= 1'b1;
            end else begin
              sck_q <= 1'b0;
              if (last) st <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          psel_q <= '1;
          if (ptr == end_ptr) begin
            if (wrap_en) begin
              ptr <= start_ptr;
              st  <= ST_FETCH;
            end else begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end
          end else begin
            ptr <= ptr_next;
            st  <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sck  = sck_q;
  assign psel = psel_q;
  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             sck,
  input logic             mosi,
  input logic [SEL_W-1:0] psel
);

  // R8
  idle_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (psel == '1));

  // R5
  sck_rest_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);

  // R5
  mosi_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi));

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(psel));

  // R9
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done));

  // R7
  sck_high_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |=> sck);

  // R7
  sck_low_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sck) |=> !sck);

endmodule

bind qspi_master qspi_master_chk #(.SEL_W(SEL_W)) u_qspi_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .sck   (sck),
  .mosi  (mosi),
  .psel  (psel)
);

// File: tb/test_qspi_master.sv
`timescale 1ns/1ps
module test_qspi_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ent_we = 1'b0;
  logic [3:0]  ent_addr = '0;
  logic [15:0] ent_tx = '0;
  logic [3:0]  ent_len = '0;
  logic [3:0]  ent_sel = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        start = 1'b0;
  logic        wrap_en = 1'b0;
  logic [3:0]  start_ptr = '0;
  logic [3:0]  end_ptr = '0;
  logic [7:0]  clk_div = 8'd8;
  logic        miso = 1'b0;
  logic        sck, mosi, busy, done;
  logic [3:0]  psel;

  always #2.5 clk = ~clk;

  qspi_master i_qspi_master (
    .clk(clk), .rst(rst), .ent_we(ent_we), .ent_addr(ent_addr),
    .ent_tx(ent_tx), .ent_len(ent_len), .ent_sel(ent_sel),
    .rd_addr(rd_addr), .rd_data(rd_data), .start(start),
    .wrap_en(wrap_en), .start_ptr(start_ptr), .end_ptr(end_ptr),
    .clk_div(clk_div), .miso(miso), .sck(sck), .mosi(mosi),
    .psel(psel), .busy(busy), .done(done)
  );

  // {tx word, length code, select code}
  localparam logic [23:0] VEC [6] = '{
    {16'h00A5, 4'd7,  4'd0},
    {16'h0ABC, 4'd11, 4'd3},
    {16'hBEEF, 4'd15, 4'd9},
    {16'h0155, 4'd8,  4'd14},
    {16'hFF3C, 4'd3,  4'd5},
    {16'h1234, 4'd12, 4'd1}
  };

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] m_tx  [16];
  logic [3:0]  m_len [16];
  logic [3:0]  m_sel [16];

  // slave model state
  int          run_id = 0;
  int          seen_run = 0;
  int          xi = 0;
  int          cnt = 0;
  int          cyc = 0;
  int          last_rise = 0;
  int          last_period = 0;
  bit          in_word = 0;
  logic        prev_sck = 0;
  logic [3:0]  prev_sel = 4'hF;
  logic [15:0] acc = '0;
  logic [15:0] got_mosi [32];
  int          got_bits [32];
  logic [3:0]  got_sel  [32];

  function automatic logic [15:0] sw(input int k);
    return 16'hC3A5 ^ (16'(k) * 16'h0F1D);
  endfunction

  function automatic int nb(input logic [3:0] code);
    return (code < 4'd7) ? 8 : int'(code) + 1;
  endfunction

  function automatic logic [15:0] mask(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (seen_run != run_id) begin
      seen_run = run_id;
      xi = 0;
    end
    if (rst) begin
      in_word = 0;
      prev_sck = 0;
      prev_sel = 4'hF;
      miso = 0;
    end else begin
      if (prev_sel == 4'hF && psel != 4'hF) begin
        in_word = 1; cnt = 0; acc = '0; got_sel[xi] = psel;
      end
      if (!prev_sck && sck) begin
        acc = {acc[14:0], mosi};
        if (cnt > 0) last_period = cyc - last_rise;
        last_rise = cyc;
        cnt++;
      end
      if (prev_sel != 4'hF && psel == 4'hF) begin
        got_mosi[xi] = acc; got_bits[xi] = cnt; in_word = 0;
        if (xi < 31) xi++;
      end
      miso = (in_word && cnt < 16) ? sw(xi)[15 - cnt] : 1'b0;
      prev_sck = sck;
      prev_sel = psel;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic put_entry(input int a, input logic [23:0] v);
    @(negedge clk);
    ent_we = 1; ent_addr = 4'(a);
    ent_tx = v[23:8]; ent_len = v[7:4]; ent_sel = v[3:0];
    m_tx[a] = v[23:8]; m_len[a] = v[7:4]; m_sel[a] = v[3:0];
    @(negedge clk);
    ent_we = 0;
  endtask

  task automatic run_q(input int sp, input int ep, input bit wr, input int dv);
    @(negedge clk);
    start_ptr = 4'(sp); end_ptr = 4'(ep); wrap_en = wr; clk_div = 8'(dv);
    run_id++;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1 && done === 1'b0, "R2 busy after start", {busy, done}, 2'b10);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_xfer(input int k, input int a);
    int n;
    n = nb(m_len[a]);
    chk(got_sel[k] == m_sel[a], "R3/R8 select order", got_sel[k], m_sel[a]);
    chk(got_bits[k] == n, "R4 bit count", got_bits[k], n);
    chk(got_mosi[k] == (m_tx[a] & mask(n)), "R4/R5 mosi word", got_mosi[k], m_tx[a] & mask(n));
  endtask

  task automatic chk_rx(input int a, input int k);
    logic [15:0] e;
    e = sw(k) >> (16 - nb(m_len[a]));
    @(negedge clk);
    rd_addr = 4'(a);
    @(negedge clk);
    chk(rd_data == e, "R6 receive slot", rd_data, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sck == 0 && psel == 4'hF && busy == 0 && done == 0, "R1 reset outputs",
        {sck, psel, busy, done}, 7'b0_1111_00);
    rst = 0;
    @(negedge clk);
    chk(sck == 0 && psel == 4'hF && busy == 0 && done == 0, "R1 after reset",
        {sck, psel, busy, done}, 7'b0_1111_00);

    for (int i = 0; i < 6; i++) put_entry(i, VEC[i]);

    // run 1: entries 0..5, divisor 8, stray start mid-run
    run_q(0, 5, 0, 8);
    repeat (20) @(negedge clk);
    start_ptr = 4'd3; start = 1;
    @(negedge clk);
    start = 0;
    wait_done();
    chk(xi == 6, "R2 stray start ignored, count", xi, 6);
    for (int k = 0; k < 6; k++) chk_xfer(k, k);
    chk(busy == 0 && done == 1, "R9 stop flags", {busy, done}, 2'b01);
    chk(last_period == 8, "R7 period div 8", last_period, 8);
    for (int k = 0; k < 6; k++) chk_rx(k, k);

    // run 2: 14,15,0,1 with index wrap, divisor 3
    put_entry(14, VEC[2]);
    put_entry(15, VEC[4]);
    run_q(14, 1, 0, 3);
    wait_done();
    chk(xi == 4, "R3 count across 15->0", xi, 4);
    chk_xfer(0, 14); chk_xfer(1, 15); chk_xfer(2, 0); chk_xfer(3, 1);
    chk(last_period == 4, "R7 period div 3 clamps", last_period, 4);
    chk_rx(14, 0); chk_rx(15, 1); chk_rx(0, 2); chk_rx(1, 3);

    // run 3: wrap mode on entries 2..3, cleared after 5 transfers
    run_q(2, 3, 1, 4);
    while (xi < 5) @(negedge clk);
    wrap_en = 0;
    wait_done();
    chk(xi == 6, "R10 stops at next end entry", xi, 6);
    for (int k = 0; k < 6; k++) chk_xfer(k, 2 + (k % 2));
    chk(last_period == 4, "R7 period div 4", last_period, 4);
    chk_rx(2, 4); chk_rx(3, 5);

    // run 4: short code on entry 4, odd divisor
    run_q(4, 4, 0, 9);
    wait_done();
    chk_xfer(0, 4);
    chk(last_period == 8, "R7 period div 9 rounds down", last_period, 8);

    // R1 reset in the middle of a transfer
    run_q(0, 5, 0, 8);
    repeat (30) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(sck == 0 && psel == 4'hF && busy == 0 && done == 0, "R1 mid-run reset",
        {sck, psel, busy, done}, 7'b0_1111_00);
    rst = 0;
    repeat (40) @(negedge clk);
    chk(sck == 0 && psel == 4'hF && busy == 0, "R1 stays idle after reset",
        {sck, psel, busy}, 6'b0_1111_0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule